// File: doc/BRIEF.md
# Chaotic-Clocked Oscillator XOR Sampler

This block turns a bank of free-running oscillator bits into a stream of random bits. All oscillator bits are folded into one bit by XOR. That bit is captured only when an external chaotic generator presents a rising edge on its one-bit strobe, so the sampling instants are non-periodic. Each captured bit is also written into an on-chip capture memory that is one bit wide. The memory has a synchronous read port, so the stream can be pulled out after a run.

The block also drives the enable multiplexer of every oscillator. While the shared select input is low, each oscillator is fed a constant 1. Because every oscillator has an odd number of inverters, its output then sits at 0. Raising select closes every feedback loop. The same select level is passed on to release the chaotic generator from seed loading, so the oscillators and the generator start on one trigger.

The strobe comes from another timing domain. It is synchronized with two flops, and a one-cycle pulse is formed on its rising edge. Once the capture memory has been filled one time, the block latches a done flag and takes no further samples until reset. The default memory depth is kept small. Setting `ADDR_W` to 16 gives the full 65,536-entry buffer, and `N_OSC` may be 25 or 114.

Top module: `osc_sampler_top`

## Requirements
- R1: `osc_drive[i]` is 1 while `sel` is 0 and equals `osc_fb[i]` while `sel` is 1, for every oscillator i, with no clock delay.
- R2: `chaos_run` follows `sel` combinationally, so the chaotic generator and the oscillator loops are released by the same level.
- R3: If `strobe` is low at clock edge k-1 and high at edge k, and `sel` is high, then after edge k+2 `rnd_valid` is 1 for exactly one cycle. At that point `rnd_bit` equals the XOR of all `osc_fb` bits present at edge k+2.
- R4: A strobe held high for many cycles gives exactly one sample. A new sample needs the strobe to go low and rise again.
- R5: A strobe rising edge whose capture edge sees `sel` low gives no `rnd_valid` pulse, no memory write and no change of the write address.
- R6: After reset the write address is 0. Each sample is stored at the current address, and the address then increments by one, so the j-th sample since reset (counting from 0) lands at address j.
- R7: The read port returns at `rd_data` the content of address `rd_addr` one clock edge after `rd_addr` is presented.
- R8: The write that fills the last address (2^ADDR_W - 1) sets `done`, which then stays 1 until reset. While `done` is 1, strobe edges produce no `rnd_valid` and leave the memory unchanged.
- R9: After reset, `rnd_valid`, `rnd_bit` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Shared start/select: 0 = hold and seed, 1 = run |
| osc_fb | input | N_OSC | Oscillator output bits (feedback taps) |
| strobe | input | 1 | Chaotic one-bit sampling signal, asynchronous |
| osc_drive | output | N_OSC | Per-oscillator enable mux outputs |
| chaos_run | output | 1 | Release signal for the chaotic generator |
| rnd_bit | output | 1 | Last sampled random bit |
| rnd_valid | output | 1 | One-cycle pulse marking a new `rnd_bit` |
| done | output | 1 | Capture memory filled, sampling stopped |
| rd_addr | input | ADDR_W | Capture memory read address |
| rd_data | output | 1 | Capture memory read data, one cycle latency |

## Verification
The mux and release outputs are combinational, so they are checked half a cycle after their inputs change. A sample is due two edges after the edge that first sees the strobe high: one edge for each synchronizer flop, with the capture register on the second. The bench therefore raises the strobe at a falling edge, waits three falling edges, and checks the valid pulse and the parity of the oscillator pattern it held steady over that window. It then checks one falling edge later that the pulse has ended. Read data is checked at the falling edge after the address was presented. The bench uses a 16-entry memory so that it can sweep the whole buffer, including the wrap into done and the writes that are blocked afterwards.

// File: rtl/osc_sampler_pkg.sv
package osc_sampler_pkg;

    // Synchronizer and edge-detect state for the chaotic strobe
    typedef struct packed {
        logic meta;   // first capture flop
        logic stab;   // second capture flop
        logic prev;   // delayed copy for edge detection
    } strobe_sync_t;

    // Largest supported capture address width
    localparam int unsigned MAX_ADDR_W = 16;

endpackage

// File: rtl/osc_gate_xor.sv
module osc_gate_xor #(
    parameter int unsigned N_OSC = 25
) (
    input  logic             sel,
    input  logic [N_OSC-1:0] osc_fb,
    output logic [N_OSC-1:0] osc_drive,
    output logic             osc_xor
);

    // Per-oscillator 2:1 enable mux: data0 = constant 1, data1 = feedback
    for (genvar g = 0; g < N_OSC; g++) begin : g_mux
        assign osc_drive[g] = sel ? osc_fb[g] : 1'b1;
    end

    // XOR fold of all oscillator outputs
    assign osc_xor = ^osc_fb;

endmodule

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync
    import osc_sampler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise_pulse
);

    strobe_sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = strobe;
        sync_d.stab = sync_q.meta;
        sync_d.prev = sync_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_pulse = sync_q.stab & ~sync_q.prev;

    // R4: a held strobe cannot yield two consecutive pulses
    // R4
    no_double_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/capture_ram.sv
module capture_ram #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic mem_q [DEPTH];
    logic rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/osc_sampler_top.sv
module osc_sampler_top
    import osc_sampler_pkg::*;
#(
    parameter int unsigned N_OSC  = 25,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [N_OSC-1:0]  osc_fb,
    input  logic              strobe,
    output logic [N_OSC-1:0]  osc_drive,
    output logic              chaos_run,
    output logic              rnd_bit,
    output logic              rnd_valid,
    output logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_data
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] wr_addr;
        logic              done;
        logic              valid;
        logic              bit_v;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic osc_xor;
    logic rise_pulse;
    logic take;

    osc_gate_xor #(.N_OSC(N_OSC)) u_gate (
        .sel       (sel),
        .osc_fb    (osc_fb),
        .osc_drive (osc_drive),
        .osc_xor   (osc_xor)
    );

    strobe_edge_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .rise_pulse (rise_pulse)
    );

    assign take = rise_pulse & sel & ~ctl_q.done;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (take) begin
            ctl_d.valid   = 1'b1;
            ctl_d.bit_v   = osc_xor;
            ctl_d.wr_addr = ctl_q.wr_addr + 1'b1;
            if (ctl_q.wr_addr == LAST_ADDR) begin
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    capture_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (take),
        .wr_addr (ctl_q.wr_addr),
        .wr_data (osc_xor),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign chaos_run = sel;
    assign rnd_bit   = ctl_q.bit_v;
    assign rnd_valid = ctl_q.valid;
    assign done      = ctl_q.done;

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |=> !rnd_valid);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rnd_valid);

    // R5
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_pulse && !sel) |=> (!rnd_valid && $stable(ctl_q.wr_addr)));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> (ctl_q.wr_addr == ADDR_W'($past(ctl_q.wr_addr) + 1'b1)));

    // R1
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> ($countones(osc_drive) == N_OSC));

endmodule

// File: tb/osc_sampler_top_test.sv
module osc_sampler_top_test;

    localparam int unsigned N_OSC  = 25;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic [N_OSC-1:0]  osc_fb = '0;
    logic              strobe = 1'b0;
    logic [N_OSC-1:0]  osc_drive;
    logic              chaos_run;
    logic              rnd_bit;
    logic              rnd_valid;
    logic              done;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic exp_mem [DEPTH];

    always #2 clk = ~clk;

    osc_sampler_top #(.N_OSC(N_OSC), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .osc_fb    (osc_fb),
        .strobe    (strobe),
        .osc_drive (osc_drive),
        .chaos_run (chaos_run),
        .rnd_bit   (rnd_bit),
        .rnd_valid (rnd_valid),
        .done      (done),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N_OSC-1:0] pat(input int j);
        logic [31:0] v;
        v = (j * 32'h9E37_79B1) ^ (j << 7) ^ 32'h0155_AA33;
        return v[N_OSC-1:0];
    endfunction

    // Raise strobe, hold pattern, check capture two edges later; then drop strobe
    task automatic sample(input logic [N_OSC-1:0] p, input bit expect_take, input string req);
        @(negedge clk);
        osc_fb = p;
        strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk({req, " no early valid"}, 32'(rnd_valid), 32'd0);
        @(negedge clk);
        chk({req, " valid"}, 32'(rnd_valid), 32'(expect_take));
        if (expect_take) begin
            chk({req, " bit parity"}, 32'(rnd_bit), 32'(^p));
        end
        strobe = 1'b0;
        @(negedge clk);
        chk({req, " pulse ends"}, 32'(rnd_valid), 32'd0);
    endtask

    task automatic read_chk(input int a, input logic exp, input string req);
        @(negedge clk);
        rd_addr = ADDR_W'(a);
        @(negedge clk);
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 valid", 32'(rnd_valid), 32'd0);
        chk("R9 bit", 32'(rnd_bit), 32'd0);
        chk("R9 done", 32'(done), 32'd0);
        rst_n = 1'b1;

        // R1 / R2: mux and release with select low, then high
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            sel = 1'b0;
            osc_fb = pat(j);
            #1;
            chk("R1 sel0 drive", 32'(osc_drive), 32'({N_OSC{1'b1}}));
            chk("R2 sel0 run", 32'(chaos_run), 32'd0);
            sel = 1'b1;
            #1;
            chk("R1 sel1 drive", 32'(osc_drive), 32'(pat(j)));
            chk("R2 sel1 run", 32'(chaos_run), 32'd1);
        end

        // R5: strobe edges while select low are ignored
        sel = 1'b0;
        sample(pat(40), 1'b0, "R5 sel low");
        sample(pat(41), 1'b0, "R5 sel low again");
        sel = 1'b1;

        // R4: strobe held high yields one sample only
        @(negedge clk);
        osc_fb = pat(0);
        strobe = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 first valid", 32'(rnd_valid), 32'd1);
        chk("R3 first bit", 32'(rnd_bit), 32'(^pat(0)));
        exp_mem[0] = ^pat(0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R4 held strobe no repeat", 32'(rnd_valid), 32'd0);
        end
        strobe = 1'b0;
        @(negedge clk);

        // R3 / R6: fill the rest of the buffer with distinct patterns
        for (int j = 1; j < DEPTH; j++) begin
            chk("R8 done not early", 32'(done), 32'd0);
            sample(pat(j), 1'b1, "R3 sample");
            exp_mem[j] = ^pat(j);
        end
        chk("R8 done after fill", 32'(done), 32'd1);

        // R6 / R7: every address holds its sample (address 0 proves R5 left it unused)
        for (int a = 0; a < DEPTH; a++) begin
            read_chk(a, exp_mem[a], "R6 R7 readback");
        end

        // R8: further strobes are blocked and memory is unchanged
        sample(~pat(0), 1'b0, "R8 blocked");
        sample(~pat(1), 1'b0, "R8 blocked again");
        chk("R8 done sticky", 32'(done), 32'd1);
        for (int a = 0; a < 2; a++) begin
            read_chk(a, exp_mem[a], "R8 memory kept");
        end

        // R9: reset clears done and valid
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 done cleared", 32'(done), 32'd0);
        chk("R9 bit cleared", 32'(rnd_bit), 32'd0);
        rst_n = 1'b1;
        sample(pat(77), 1'b1, "R6 restart");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule